// File: doc/BRIEF.md
# Tearing-Effect Synchronised Frame Start

This block decides when a frame transfer toward an external display panel may begin. The panel reports its refresh position on one or two sync wires. The block recovers line and frame markers from those wires and counts lines from the start of each frame. It then issues a single start pulse when the panel's scan reaches a programmed line, so that new pixels never overtake the scan and no tear shows.

The shared-wire mode carries both markers on one input and tells them apart by how long each pulse lasts, against two programmed width thresholds. The two-wire mode uses a separate wire for each marker. With synchronisation switched off, a software trigger starts the transfer at once.

Once started, the transfer runs for a programmed number of pixels, counted by an accept handshake from the pixel path. It ends with a one-cycle completion pulse and the enable is dropped.

Top module: `tear_sync_trigger`

## Requirements
- R1: `syncMode` selects the mode. 0 means synchronisation off. 1 means shared-wire mode, with both markers on `teA`. 2 means two-wire mode, with line markers on `teA` and frame markers on `teB`. 3 behaves exactly like 0.
- R2: `hsPolHigh` sets the active level of `teA` and `vsPolHigh` sets the active level of `teB`. A value of 1 means active high and 0 means active low. In shared-wire mode `teA` follows `hsPolHigh`.
- R3: In shared-wire mode a pulse's width is the number of clock edges on which `teA` is sampled active. A width of at least `vsWidth` is a frame marker. A width of at least `hsWidth` but below `vsWidth` is a line marker. Any shorter pulse is ignored. A marker is recognised when the pulse ends.
- R4: In two-wire mode each rising edge of the active level on `teA` is a line marker, and each on `teB` is a frame marker. When both arrive on the same cycle, the frame marker wins and that line marker is not counted.
- R5: A frame marker sets the line count to 0, and each line marker adds 1. With synchronisation on, enable set, no transfer running and at least one frame marker seen, `startPulse` rises once when the line count equals `lineNum`. This happens three clock edges after the marker edge is sampled. No further start comes in that frame.
- R6: A one-cycle `xferEnSet` loads `pixelCount` and sets `xferEn`, unless a transfer is running. No start pulse is ever issued while `xferEn` is low.
- R7: With synchronisation off, `swTrigSet` sets `swTrigPend`. A start then follows as soon as `xferEn` is set and no transfer runs, and the pending bit clears with it. With synchronisation on, `swTrigSet` is ignored.
- R8: `pixAccept` counts down the loaded pixel count only while a transfer runs. When the count is zero, `frameDone` pulses for one cycle and `xferEn` and `xferBusy` clear.
- R9: After reset `xferEn`, `xferBusy`, `swTrigPend`, `startPulse` and `frameDone` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| syncMode | input | 2 | Sync mode select |
| hsWidth | input | WID_W | Minimum line-marker width in clocks (shared wire) |
| vsWidth | input | WID_W | Minimum frame-marker width in clocks (shared wire) |
| hsPolHigh | input | 1 | Active level of teA |
| vsPolHigh | input | 1 | Active level of teB |
| lineNum | input | LINE_W | Line at which the transfer starts |
| teA | input | 1 | Shared or line sync wire from the panel |
| teB | input | 1 | Frame sync wire from the panel (two-wire mode) |
| pixelCount | input | PIX_W | Pixels per transfer, loaded by xferEnSet |
| xferEnSet | input | 1 | Arm the transfer and load the pixel count |
| swTrigSet | input | 1 | Software start request |
| pixAccept | input | 1 | Pixel-path accept handshake |
| xferEn | output | 1 | Transfer enable bit |
| xferBusy | output | 1 | Transfer running |
| swTrigPend | output | 1 | Software start pending |
| startPulse | output | 1 | One-cycle transfer start |
| frameDone | output | 1 | One-cycle completion |

## Verification
In two-wire mode, a line marker and a frame marker can land on the same cycle and both try to change the line counter. The bench provokes this by raising `teA` and `teB` on the same edge with a target line of 1. It judges the outcome by the start pulse: no start may follow the coincident pair, and a start must follow the next lone line marker. Two other sweeps judge every result arithmetically from the programmed values: the shared-wire pulse width is swept across both thresholds, and the target line is swept under both polarities.

// File: rtl/tst_pkg.sv
package tst_pkg;
  typedef enum logic [1:0] {
    SM_OFF = 2'd0,
    SM_ONE = 2'd1,
    SM_TWO = 2'd2,
    SM_RSV = 2'd3
  } sync_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadPix;
    logic countEn;
  } tst_strobe_t;
endpackage

// File: rtl/tst_datapath.sv
module tst_datapath
  import tst_pkg::*;
#(
  parameter int WID_W  = 6,
  parameter int LINE_W = 11,
  parameter int PIX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sync_mode_e        mode,
  input  logic [WID_W-1:0]  hsWidth,
  input  logic [WID_W-1:0]  vsWidth,
  input  logic              hsPolHigh,
  input  logic              vsPolHigh,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              teA,
  input  logic              teB,
  input  logic [PIX_W-1:0]  pixelCount,
  input  logic              pixAccept,
  input  tst_strobe_t       stb,
  output logic              hsEv,
  output logic              vsEv,
  output logic              lineHit,
  output logic              pixZero
);
  localparam int NCH = 2;
  localparam logic [WID_W-1:0]  RUN_MAX  = {WID_W{1'b1}};
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [NCH-1:0] pinIn, polHi, lvl, prv, rise;
  assign pinIn = {teB, teA};
  assign polHi = {vsPolHigh, hsPolHigh};

  // per-wire polarity correction and edge detection
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic lvlQ, prvQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvlQ <= 1'b0;
        prvQ <= 1'b0;
      end else begin
        lvlQ <= polHi[c] ? pinIn[c] : ~pinIn[c];
        prvQ <= lvlQ;
      end
    end
    assign lvl[c]  = lvlQ;
    assign prv[c]  = prvQ;
    assign rise[c] = lvlQ & ~prvQ;
  end

  // pulse width measurement on the shared wire
  logic [WID_W-1:0] runLen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                runLen <= '0;
    else if (!lvl[0])          runLen <= '0;
    else if (runLen != RUN_MAX) runLen <= runLen + 1'b1;
  end

  logic pulseEnd, oneHs, oneVs;
  assign pulseEnd = prv[0] & ~lvl[0];
  assign oneVs    = pulseEnd && (runLen >= vsWidth);
  assign oneHs    = pulseEnd && (runLen >= hsWidth) && (runLen < vsWidth);

  always_comb begin
    hsEv = 1'b0;
    vsEv = 1'b0;
    case (mode)
      SM_ONE: begin hsEv = oneHs;   vsEv = oneVs;   end
      SM_TWO: begin hsEv = rise[0]; vsEv = rise[1]; end
      default: ;
    endcase
  end

  // line counter
  logic [LINE_W-1:0] lineCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            lineCnt <= '0;
    else if (vsEv)                         lineCnt <= '0;
    else if (hsEv && lineCnt != LINE_MAX)  lineCnt <= lineCnt + 1'b1;
  end
  assign lineHit = (lineCnt == lineNum);

  // pixel counter
  logic [PIX_W-1:0] pixCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                pixCnt <= '0;
    else if (stb.loadPix)                      pixCnt <= pixelCount;
    else if (stb.countEn && pixAccept && !pixZero) pixCnt <= pixCnt - 1'b1;
  end
  assign pixZero = (pixCnt == '0);

  // R5: a frame marker restarts the line count
  a_r5_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
    vsEv |=> (lineCnt == '0));
  // R5: the line count moves by at most one per cycle unless restarted
  a_r5_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    !vsEv |=> (lineCnt == $past(lineCnt)) || (lineCnt == $past(lineCnt) + 1'b1));
  // R8: the pixel count never rises except on a load
  a_r8_pix_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.loadPix |=> (pixCnt <= $past(pixCnt)));
endmodule

// File: rtl/tst_ctrl.sv
module tst_ctrl
  import tst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  sync_mode_e  mode,
  input  logic        xferEnSet,
  input  logic        swTrigSet,
  input  logic        vsEv,
  input  logic        lineHit,
  input  logic        pixZero,
  output tst_strobe_t stb,
  output logic        xferEn,
  output logic        xferBusy,
  output logic        swTrigPend,
  output logic        startPulse,
  output logic        frameDone
);
  logic syncOn, frameSeen, fired, syncGo, swGo, go, done;

  assign syncOn = (mode == SM_ONE) || (mode == SM_TWO);
  assign syncGo = syncOn && xferEn && !xferBusy && frameSeen && !fired && lineHit && !vsEv;
  assign swGo   = !syncOn && swTrigPend && xferEn && !xferBusy;
  assign go     = syncGo || swGo;
  assign done   = xferBusy && pixZero;

  assign stb.loadPix = xferEnSet && !xferBusy;
  assign stb.countEn = xferBusy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xferEn     <= 1'b0;
      xferBusy   <= 1'b0;
      swTrigPend <= 1'b0;
      startPulse <= 1'b0;
      frameDone  <= 1'b0;
      frameSeen  <= 1'b0;
      fired      <= 1'b0;
    end else begin
      startPulse <= go;
      frameDone  <= done;

      if (!syncOn) begin
        frameSeen <= 1'b0;
        fired     <= 1'b0;
      end else if (vsEv) begin
        frameSeen <= 1'b1;
        fired     <= 1'b0;
      end else if (syncGo) begin
        fired <= 1'b1;
      end

      if (swGo)                      swTrigPend <= 1'b0;
      else if (swTrigSet && !syncOn) swTrigPend <= 1'b1;

      if (go)        xferBusy <= 1'b1;
      else if (done) xferBusy <= 1'b0;

      if (done)           xferEn <= 1'b0;
      else if (xferEnSet) xferEn <= 1'b1;
    end
  end

  // R5: a start is a single-cycle pulse
  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);
  // R6: no start without the enable bit
  a_r6_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> xferEn);
  // R8: completion drops the enable
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> !xferEn);
  // R8: completion leaves the block idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> !xferBusy);
endmodule

// File: rtl/tear_sync_trigger.sv
module tear_sync_trigger
  import tst_pkg::*;
#(
  parameter int WID_W  = 6,
  parameter int LINE_W = 11,
  parameter int PIX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        syncMode,
  input  logic [WID_W-1:0]  hsWidth,
  input  logic [WID_W-1:0]  vsWidth,
  input  logic              hsPolHigh,
  input  logic              vsPolHigh,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              teA,
  input  logic              teB,
  input  logic [PIX_W-1:0]  pixelCount,
  input  logic              xferEnSet,
  input  logic              swTrigSet,
  input  logic              pixAccept,
  output logic              xferEn,
  output logic              xferBusy,
  output logic              swTrigPend,
  output logic              startPulse,
  output logic              frameDone
);
  sync_mode_e  mode;
  tst_strobe_t stb;
  logic hsEv, vsEv, lineHit, pixZero;

  assign mode = sync_mode_e'(syncMode);

  tst_datapath #(.WID_W(WID_W), .LINE_W(LINE_W), .PIX_W(PIX_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .hsWidth(hsWidth), .vsWidth(vsWidth),
    .hsPolHigh(hsPolHigh), .vsPolHigh(vsPolHigh),
    .lineNum(lineNum), .teA(teA), .teB(teB),
    .pixelCount(pixelCount), .pixAccept(pixAccept), .stb(stb),
    .hsEv(hsEv), .vsEv(vsEv), .lineHit(lineHit), .pixZero(pixZero)
  );

  tst_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .xferEnSet(xferEnSet), .swTrigSet(swTrigSet),
    .vsEv(vsEv), .lineHit(lineHit), .pixZero(pixZero),
    .stb(stb), .xferEn(xferEn), .xferBusy(xferBusy),
    .swTrigPend(swTrigPend), .startPulse(startPulse), .frameDone(frameDone)
  );
endmodule

// File: tb/tear_sync_trigger_tb.sv
module tear_sync_trigger_tb_top;
  localparam int WID_W = 6, LINE_W = 11, PIX_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] syncMode = 2'd0;
  logic [WID_W-1:0] hsWidth = 6'd3, vsWidth = 6'd6;
  logic hsPolHigh = 1'b1, vsPolHigh = 1'b1;
  logic [LINE_W-1:0] lineNum = '0;
  logic teA = 1'b0, teB = 1'b0;
  logic [PIX_W-1:0] pixelCount = '0;
  logic xferEnSet = 1'b0, swTrigSet = 1'b0, pixAccept = 1'b0;
  logic xferEn, xferBusy, swTrigPend, startPulse, frameDone;

  int vectors = 0, miscompares = 0;
  int startCnt = 0, doneCnt = 0, cyc = 0, lastStartCyc = -1;

  always #5 clk = ~clk;

  tear_sync_trigger #(.WID_W(WID_W), .LINE_W(LINE_W), .PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .syncMode(syncMode),
    .hsWidth(hsWidth), .vsWidth(vsWidth),
    .hsPolHigh(hsPolHigh), .vsPolHigh(vsPolHigh), .lineNum(lineNum),
    .teA(teA), .teB(teB), .pixelCount(pixelCount),
    .xferEnSet(xferEnSet), .swTrigSet(swTrigSet), .pixAccept(pixAccept),
    .xferEn(xferEn), .xferBusy(xferBusy), .swTrigPend(swTrigPend),
    .startPulse(startPulse), .frameDone(frameDone)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (startPulse) begin startCnt <= startCnt + 1; lastStartCyc <= cyc; end
    if (frameDone) doneCnt <= doneCnt + 1;
  end

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseIn(input bit onB, input int w);
    if (onB) teB = vsPolHigh; else teA = hsPolHigh;
    tick(w);
    if (onB) teB = ~vsPolHigh; else teA = ~hsPolHigh;
  endtask

  task automatic armXfer(input int pix);
    pixelCount = PIX_W'(pix);
    xferEnSet = 1'b1; tick(1); xferEnSet = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && xferBusy; i++) begin
      pixAccept = 1'b1; tick(1); pixAccept = 1'b0; tick(1);
    end
    tick(3);
  endtask

  task automatic setIdle(input logic [1:0] m, input bit hp, input bit vp);
    syncMode = 2'd0;
    hsPolHigh = hp; vsPolHigh = vp;
    teA = ~hp; teB = ~vp;
    tick(3);
    syncMode = m;
    tick(1);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int s0, d0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R9 reset state
    chk("R9 xferEn", xferEn, 0);
    chk("R9 xferBusy", xferBusy, 0);
    chk("R9 swTrigPend", swTrigPend, 0);
    chk("R9 startPulse", startPulse, 0);
    chk("R9 frameDone", frameDone, 0);

    // R8: accepts while idle are ignored, countdown only while running
    setIdle(2'd0, 1'b1, 1'b1);
    armXfer(3);
    repeat (2) begin pixAccept = 1'b1; tick(1); pixAccept = 1'b0; tick(1); end
    s0 = startCnt; d0 = doneCnt;
    swTrigSet = 1'b1; tick(1); swTrigSet = 1'b0; tick(4);
    chk("R7 sw start", startCnt - s0, 1);
    chk("R7 pend cleared", swTrigPend, 0);
    chk("R8 busy", xferBusy, 1);
    repeat (2) begin pixAccept = 1'b1; tick(1); pixAccept = 1'b0; tick(1); end
    tick(3);
    chk("R8 no early done", doneCnt - d0, 0);
    pixAccept = 1'b1; tick(1); pixAccept = 1'b0; tick(4);
    chk("R8 done pulse", doneCnt - d0, 1);
    chk("R8 enable cleared", xferEn, 0);
    chk("R8 busy cleared", xferBusy, 0);

    // R6: no start without enable; R7 pending waits for enable
    s0 = startCnt;
    swTrigSet = 1'b1; tick(1); swTrigSet = 1'b0; tick(5);
    chk("R6 no start unarmed", startCnt - s0, 0);
    chk("R7 pend held", swTrigPend, 1);
    armXfer(1); tick(4);
    chk("R6 start after arm", startCnt - s0, 1);
    drain();

    // R1: mode 3 behaves as off
    setIdle(2'd3, 1'b1, 1'b1);
    s0 = startCnt;
    armXfer(1);
    swTrigSet = 1'b1; tick(1); swTrigSet = 1'b0; tick(4);
    chk("R1 mode3 sw start", startCnt - s0, 1);
    drain();

    // R7: software trigger ignored with sync on
    setIdle(2'd2, 1'b1, 1'b1);
    s0 = startCnt;
    armXfer(1);
    swTrigSet = 1'b1; tick(1); swTrigSet = 1'b0; tick(5);
    chk("R7 sw ignored pend", swTrigPend, 0);
    chk("R7 sw ignored start", startCnt - s0, 0);

    // R5/R2/R4: two-wire line sweep, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int L = 0; L < 5; L++) begin
        int vcyc;
        setIdle(2'd2, pol[0], pol[0]);
        lineNum = LINE_W'(L);
        armXfer(1);
        s0 = startCnt;
        vcyc = cyc;
        pulseIn(1'b1, 2); tick(5);
        chk("R5 after frame marker", startCnt - s0, (L == 0) ? 1 : 0);
        if (L == 0) chk("R5 start latency", lastStartCyc - vcyc, 3);
        for (int k = 1; k <= 6; k++) begin
          pulseIn(1'b0, 2); tick(4);
          chk("R5 line sweep", startCnt - s0, (k >= L) ? 1 : 0);
        end
        drain();
      end
    end

    // R4: coincident markers, frame wins
    setIdle(2'd2, 1'b1, 1'b0);
    lineNum = LINE_W'(1);
    armXfer(1);
    s0 = startCnt;
    teA = 1'b1; teB = 1'b0; tick(2); teA = 1'b0; teB = 1'b1; tick(5);
    chk("R4 coincident no start", startCnt - s0, 0);
    pulseIn(1'b0, 2); tick(5);
    chk("R4 start after lone line", startCnt - s0, 1);
    drain();

    // R3/R2: shared-wire width sweep against thresholds 3 and 6
    for (int pol = 0; pol < 2; pol++) begin
      for (int w = 1; w <= 9; w++) begin
        setIdle(2'd1, pol[0], 1'b1);
        lineNum = LINE_W'(1);
        armXfer(1);
        s0 = startCnt;
        pulseIn(1'b0, 6); tick(4);
        pulseIn(1'b0, w); tick(5);
        chk("R3 width class", startCnt - s0, (w >= 3 && w < 6) ? 1 : 0);
        drain();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule